// File: doc/BRIEF.md
# Memory-Resident Sixteen-Channel Edge Counter

This block counts edges on sixteen asynchronous event pins without giving any channel a counter register of its own. Every pin passes through a synchroniser and an edge detector. Each detected edge adds one to a small pending tally for that channel. A single sequencer then works through the channels that have a pending tally. For each one it reads that channel's 16-bit count from a word-wide RAM, adds one, and writes the result back. After the write it takes one off the tally.

The counts occupy one aligned 32-byte window in the RAM. The window starts at a byte base address that software loads through a small register port. The same port sets the active edge polarity, two enables that must both be on, and a per-channel enable mask. A host memory port lets the surrounding system preset counts and read them out. The request output is high for as long as any channel has work waiting.

Top module: `ram_event_counter`

## Requirements
- R1: While reset is asserted and just after it is released, `evt_irq` is low and no channel has a pending event.
- R2: Control bit 2 selects the counted edge: 0 counts low-to-high transitions of a pin, 1 counts high-to-low transitions. Transitions in the other direction are ignored.
- R3: An edge is taken only when control bit 0 (counter on) and control bit 1 (transfer on) are both 1 and bit n of the channel mask register is 1. Any other edge leaves every count unchanged and `evt_irq` low.
- R4: `evt_irq` rises on the third rising clock edge after a qualifying pin change. It stays high until the write-back of the last pending event and falls at that clock edge.
- R5: The count of channel n lives at RAM word index (base byte address)/2 + n. Bits 4:0 of the written base value are ignored, so the sixteen words always form an aligned 32-byte window.
- R6: Each taken edge on channel n raises the stored word of channel n by exactly one and leaves all other words unchanged.
- R7: Each service takes one arbitration cycle followed by a read cycle, an add cycle and a write cycle. When several channels are pending, the lowest-numbered channel is served first.
- R8: An edge that arrives while its channel already has a pending or in-progress update is kept, up to three outstanding events per channel, and is counted later.
- R9: A stored count of 16'hFFFF becomes 16'h0000 on the next event, with no other effect.
- R10: The host port writes `mem_wdata` to word `mem_addr` when `mem_we` is 1. `mem_rdata` shows the word at the `mem_addr` sampled on the previous clock edge. A sequencer write in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pin | input | 16 | Asynchronous event pins, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base address, 1 control, 2 channel mask |
| cfg_wdata | input | 16 | Register write data |
| mem_we | input | 1 | Host RAM write strobe |
| mem_addr | input | 7 | Host RAM word index for read and write |
| mem_wdata | input | 16 | Host RAM write data |
| mem_rdata | output | 16 | Host RAM read data, one cycle after the address |
| evt_irq | output | 1 | High while any channel has a pending event |

## Verification
A pin change made just after clock edge E-1 reaches the pending tally at edge E2, so `evt_irq` is sampled after E1 (still low) and after E2 (high). The first write-back lands at E6 and the next one at E10. The bench therefore reads the lower channel's word at E7 and the higher one at E8, and expects `evt_irq` to fall exactly at E10. Every other result is checked only once `evt_irq` has dropped and one more edge has passed, so every write has reached the RAM. Host reads are sampled one edge after the address is driven.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_ADD   = 2'd2,
      SEQ_WRITE = 2'd3
   } seq_state_t;

   localparam logic [1:0] REG_BASE = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_MASK = 2'd2;

   localparam int CTRL_RUN  = 0;
   localparam int CTRL_XFER = 1;
   localparam int CTRL_FALL = 2;

endpackage

// File: rtl/evt_chan_slot.sv
module evt_chan_slot #(
   parameter int SYNC_STAGES = 2,
   parameter int PEND_W      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic arm,
   input  logic fall_sel,
   input  logic done,
   output logic pending
);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   level;
   logic                   hit;
   logic [PEND_W-1:0]      tally_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evt_chan_slot: SYNC_STAGES must be at least 2");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("evt_chan_slot: PEND_W must be at least 1");
   end

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= level;
      end
   end

   always_comb begin
      if (fall_sel) hit = arm & prev_q & ~level;
      else          hit = arm & ~prev_q & level;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally_q <= '0;
      end else begin
         case ({hit, done})
            2'b10:   if (tally_q != PEND_MAX) tally_q <= tally_q + 1'b1;
            2'b01:   tally_q <= tally_q - 1'b1;
            default: tally_q <= tally_q;
         endcase
      end
   end

   assign pending = |tally_q;

endmodule

// File: rtl/evt_seq.sv
module evt_seq
   import evt_cnt_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend,
   output seq_state_t        state,
   output logic [CH_W-1:0]   cur_ch,
   output logic [NUM_CH-1:0] done
);
   logic [CH_W-1:0] pick;
   logic            any;

   always_comb begin
      pick = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend[i]) pick = CH_W'(i);
      end
   end

   assign any = |pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         cur_ch <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (any) begin
               state  <= SEQ_READ;
               cur_ch <= pick;
            end
            SEQ_READ:  state <= SEQ_ADD;
            SEQ_ADD:   state <= SEQ_WRITE;
            default:   state <= SEQ_IDLE;
         endcase
      end
   end

   assign done = (state == SEQ_WRITE) ? (NUM_CH'(1) << cur_ch) : '0;

endmodule

// File: rtl/evt_word_ram.sv
module evt_word_ram #(
   parameter int DATA_W = 16,
   parameter int AW     = 7,
   parameter int DEPTH  = 1 << AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     a_raddr,
   output logic [DATA_W-1:0] a_rdata,
   input  logic [AW-1:0]     b_raddr,
   output logic [DATA_W-1:0] b_rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      a_rdata <= mem[a_raddr];
      b_rdata <= mem[b_raddr];
   end

endmodule

// File: rtl/ram_event_counter.sv
module ram_event_counter
   import evt_cnt_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 8,
   parameter int CFG_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int PEND_W      = 2,
   parameter int BYTE_SH     = $clog2(CNT_W / 8),
   parameter int WORD_AW     = ADDR_W - BYTE_SH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  evt_pin,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               mem_we,
   input  logic [WORD_AW-1:0] mem_addr,
   input  logic [CNT_W-1:0]   mem_wdata,
   output logic [CNT_W-1:0]   mem_rdata,
   output logic               evt_irq
);
   localparam int CH_W      = $clog2(NUM_CH);
   localparam int ALIGN_W   = CH_W + BYTE_SH;
   localparam int BASE_HI_W = ADDR_W - ALIGN_W;

   if ((CNT_W % 8) != 0 || (1 << BYTE_SH) * 8 != CNT_W) begin : g_bad_cnt
      $error("ram_event_counter: CNT_W must be a power-of-two number of bytes");
   end
   if ((1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("ram_event_counter: NUM_CH must be a power of two");
   end
   if (BASE_HI_W < 1) begin : g_bad_addr
      $error("ram_event_counter: ADDR_W too small for the count window");
   end
   if (CFG_W < NUM_CH || CFG_W < ADDR_W || CFG_W < 3) begin : g_bad_cfg
      $error("ram_event_counter: CFG_W too narrow");
   end

   logic [BASE_HI_W-1:0] base_hi;
   logic                 run_en;
   logic                 xfer_en;
   logic                 fall_sel;
   logic [NUM_CH-1:0]    ch_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_hi  <= '0;
         run_en   <= 1'b0;
         xfer_en  <= 1'b0;
         fall_sel <= 1'b0;
         ch_en    <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            REG_BASE: base_hi <= cfg_wdata[ADDR_W-1:ALIGN_W];
            REG_CTRL: begin
               run_en   <= cfg_wdata[CTRL_RUN];
               xfer_en  <= cfg_wdata[CTRL_XFER];
               fall_sel <= cfg_wdata[CTRL_FALL];
            end
            REG_MASK: ch_en <= cfg_wdata[NUM_CH-1:0];
            default:  ;
         endcase
      end
   end

   logic [NUM_CH-1:0] arm;
   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] done;

   assign arm = ch_en & {NUM_CH{run_en & xfer_en}};

   for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
      evt_chan_slot #(
         .SYNC_STAGES(SYNC_STAGES),
         .PEND_W     (PEND_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (evt_pin[n]),
         .arm     (arm[n]),
         .fall_sel(fall_sel),
         .done    (done[n]),
         .pending (pend[n])
      );
   end

   seq_state_t      state;
   logic [CH_W-1:0] cur_ch;

   evt_seq #(
      .NUM_CH(NUM_CH),
      .CH_W  (CH_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .state (state),
      .cur_ch(cur_ch),
      .done  (done)
   );

   logic [WORD_AW-1:0] seq_addr;
   logic [CNT_W-1:0]   seq_rdata;
   logic [CNT_W-1:0]   sum_q;
   logic               seq_we;
   logic               ram_we;
   logic [WORD_AW-1:0] ram_waddr;
   logic [CNT_W-1:0]   ram_wdata;

   assign seq_addr = {base_hi, cur_ch};
   assign seq_we   = (state == SEQ_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n)                sum_q <= '0;
      else if (state == SEQ_ADD) sum_q <= seq_rdata + CNT_W'(1);
   end

   assign ram_we    = seq_we | mem_we;
   assign ram_waddr = seq_we ? seq_addr : mem_addr;
   assign ram_wdata = seq_we ? sum_q : mem_wdata;

   evt_word_ram #(
      .DATA_W(CNT_W),
      .AW    (WORD_AW)
   ) u_ram (
      .clk    (clk),
      .we     (ram_we),
      .waddr  (ram_waddr),
      .wdata  (ram_wdata),
      .a_raddr(seq_addr),
      .a_rdata(seq_rdata),
      .b_raddr(mem_addr),
      .b_rdata(mem_rdata)
   );

   assign evt_irq = |pend;

endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk
   import evt_cnt_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int CNT_W     = 16,
   parameter int WORD_AW   = 7,
   parameter int BASE_HI_W = 3,
   parameter int CH_W      = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 evt_irq,
   input logic [NUM_CH-1:0]    pend,
   input seq_state_t           state,
   input logic [CH_W-1:0]      cur_ch,
   input logic                 seq_we,
   input logic [WORD_AW-1:0]   seq_addr,
   input logic [BASE_HI_W-1:0] base_hi,
   input logic [CNT_W-1:0]     seq_rdata,
   input logic [CNT_W-1:0]     sum_q,
   input logic                 run_en,
   input logic                 xfer_en
);
   function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) if (v[i]) r = CH_W'(i);
      return r;
   endfunction

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !evt_irq); // R1

   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_en && xfer_en) |=> ($countones(pend) <= $countones($past(pend)))); // R3

   AST_BUSY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_IDLE) |-> evt_irq); // R4

   AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      seq_we |-> (seq_addr[WORD_AW-1:CH_W] == base_hi)); // R5

   AST_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WRITE) |-> (sum_q == $past(seq_rdata) + CNT_W'(1))); // R6

   AST_READ_TO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_READ) |=> (state == SEQ_ADD)); // R7

   AST_ADD_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_ADD) |=> (state == SEQ_WRITE)); // R7

   AST_WRITE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WRITE) |=> (state == SEQ_IDLE)); // R7

   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && evt_irq) |=> (cur_ch == lowest_set($past(pend)))); // R7

endmodule

bind ram_event_counter evt_counter_chk #(
   .NUM_CH   (NUM_CH),
   .CNT_W    (CNT_W),
   .WORD_AW  (WORD_AW),
   .BASE_HI_W(BASE_HI_W),
   .CH_W     (CH_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_irq  (evt_irq),
   .pend     (pend),
   .state    (state),
   .cur_ch   (cur_ch),
   .seq_we   (seq_we),
   .seq_addr (seq_addr),
   .base_hi  (base_hi),
   .seq_rdata(seq_rdata),
   .sum_q    (sum_q),
   .run_en   (run_en),
   .xfer_en  (xfer_en)
);

// File: tb/test_ram_event_counter.sv
module test_ram_event_counter;
   localparam int NUM_CH  = 16;
   localparam int CNT_W   = 16;
   localparam int WORD_AW = 7;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_CH-1:0]  evt_pin = '0;
   logic               cfg_we = 1'b0;
   logic [1:0]         cfg_sel = '0;
   logic [15:0]        cfg_wdata = '0;
   logic               mem_we = 1'b0;
   logic [WORD_AW-1:0] mem_addr = '0;
   logic [CNT_W-1:0]   mem_wdata = '0;
   logic [CNT_W-1:0]   mem_rdata;
   logic               evt_irq;

   always #4 clk = ~clk;

   ram_event_counter i_ram_event_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_pin  (evt_pin),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .evt_irq  (evt_irq)
   );

   int          checks = 0;
   int          errors = 0;
   bit          ended  = 1'b0;
   logic [15:0] exp_cnt [NUM_CH];
   int          base_w = 0;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
      end
   endtask

   task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic mem_wr(input int a, input logic [15:0] d);
      mem_we = 1'b1; mem_addr = WORD_AW'(a); mem_wdata = d;
      tick(1);
      mem_we = 1'b0;
   endtask

   task automatic mem_rd(input int a, output logic [15:0] d);
      mem_addr = WORD_AW'(a);
      tick(1);
      d = mem_rdata;
   endtask

   task automatic wait_idle(input string req);
      int guard;
      guard = 0;
      while (evt_irq && guard < 400) begin
         tick(1);
         guard++;
      end
      check(req, "request drained", {31'd0, evt_irq}, 32'd0);
      tick(1);
   endtask

   task automatic read_all(input string req);
      logic [15:0] v;
      for (int n = 0; n < NUM_CH; n++) begin
         mem_rd(base_w + n, v);
         check(req, $sformatf("count ch%0d", n), {16'd0, v}, {16'd0, exp_cnt[n]});
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [15:0] m;
      for (int n = 0; n < NUM_CH; n++) exp_cnt[n] = '0;

      // R1: reset state
      tick(3);
      check("R1", "irq in reset", {31'd0, evt_irq}, 32'd0);
      rst_n = 1'b1;
      tick(2);
      check("R1", "irq after reset", {31'd0, evt_irq}, 32'd0);

      // R10: host port clear and write/read
      for (int a = 0; a < (1 << WORD_AW); a++) mem_wr(a, 16'h0000);
      mem_wr(100, 16'hA5C3);
      mem_rd(100, v);
      check("R10", "host readback", {16'd0, v}, 32'h0000A5C3);
      mem_wr(100, 16'h0000);

      // R5: base 0x2B behaves as 0x20 (word 16)
      wr_cfg(2'd0, 16'h002B);
      base_w = 16;
      wr_cfg(2'd2, 16'hFFFF);
      wr_cfg(2'd1, 16'h0003);

      // R4/R7: channels 3 and 9 together; pins change just after E-1
      evt_pin = 16'h0208;
      tick(2);
      check("R4", "irq after E1", {31'd0, evt_irq}, 32'd0);
      tick(1);
      check("R4", "irq after E2", {31'd0, evt_irq}, 32'd1);
      tick(4);
      mem_rd(base_w + 3, v);
      check("R7", "ch3 served first", {16'd0, v}, 32'd1);
      mem_rd(base_w + 9, v);
      check("R7", "ch9 still waiting", {16'd0, v}, 32'd0);
      tick(1);
      check("R4", "irq before last write", {31'd0, evt_irq}, 32'd1);
      tick(1);
      check("R4", "irq falls at last write", {31'd0, evt_irq}, 32'd0);
      exp_cnt[3] = 16'd1;
      exp_cnt[9] = 16'd1;
      evt_pin = '0;
      tick(4);
      mem_rd(base_w + 9, v);
      check("R5", "ch9 at base/2+9", {16'd0, v}, 32'd1);

      // R6/R2: rising sweep, channel n gets (3n mod 4) events
      for (int r = 0; r < 3; r++) begin
         m = '0;
         for (int n = 0; n < NUM_CH; n++)
            if (r < ((3 * n) % 4)) begin m[n] = 1'b1; exp_cnt[n]++; end
         evt_pin = m;
         tick(4);
         evt_pin = '0;
         tick(4);
         wait_idle("R6");
      end
      read_all("R6");

      // R2: falling polarity, rises ignored
      wr_cfg(2'd1, 16'h0007);
      for (int r = 0; r < 2; r++) begin
         m = '0;
         for (int n = 0; n < NUM_CH; n++)
            if (((n + r) % 3) != 0) begin m[n] = 1'b1; exp_cnt[n]++; end
         evt_pin = m;
         tick(6);
         check("R2", "rise ignored when falling selected", {31'd0, evt_irq}, 32'd0);
         evt_pin = '0;
         tick(4);
         wait_idle("R2");
      end
      read_all("R2");

      // R3: transfer enable off, then counter enable off
      wr_cfg(2'd1, 16'h0005);
      evt_pin = '1; tick(4); evt_pin = '0; tick(8);
      check("R3", "irq with transfer off", {31'd0, evt_irq}, 32'd0);
      wr_cfg(2'd1, 16'h0006);
      evt_pin = '1; tick(4); evt_pin = '0; tick(8);
      check("R3", "irq with counter off", {31'd0, evt_irq}, 32'd0);
      read_all("R3");
      // R3: channel mask keeps only channels 0..7
      wr_cfg(2'd1, 16'h0007);
      wr_cfg(2'd2, 16'h00FF);
      evt_pin = '1; tick(4); evt_pin = '0; tick(4);
      wait_idle("R3");
      for (int n = 0; n < 8; n++) exp_cnt[n]++;
      read_all("R3");
      wr_cfg(2'd2, 16'hFFFF);

      // R8: three quick rising edges on channel 5
      wr_cfg(2'd1, 16'h0003);
      for (int k = 0; k < 3; k++) begin
         evt_pin[5] = 1'b1; tick(1);
         evt_pin[5] = 1'b0; tick(1);
      end
      tick(4);
      wait_idle("R8");
      exp_cnt[5] = exp_cnt[5] + 16'd3;
      mem_rd(base_w + 5, v);
      check("R8", "ch5 kept all three edges", {16'd0, v}, {16'd0, exp_cnt[5]});

      // R9: wrap on channel 12, carry on channel 13
      mem_wr(base_w + 12, 16'hFFFF);
      mem_wr(base_w + 13, 16'h7FFF);
      exp_cnt[12] = 16'h0000;
      exp_cnt[13] = 16'h8000;
      evt_pin = 16'h3000; tick(4); evt_pin = '0; tick(4);
      wait_idle("R9");
      read_all("R9");

      // R5: base 0x5F behaves as 0x40 (word 32); old window untouched
      wr_cfg(2'd0, 16'h005F);
      evt_pin = 16'h8001; tick(4); evt_pin = '0; tick(4);
      wait_idle("R5");
      mem_rd(32, v);
      check("R5", "ch0 at new window", {16'd0, v}, 32'd1);
      mem_rd(47, v);
      check("R5", "ch15 at new window", {16'd0, v}, 32'd1);
      mem_rd(16, v);
      check("R6", "old window ch0 unchanged", {16'd0, v}, {16'd0, exp_cnt[0]});
      mem_rd(31, v);
      check("R6", "old window ch15 unchanged", {16'd0, v}, {16'd0, exp_cnt[15]});

      finish_run();
   end

endmodule